// File: doc/BRIEF.md
# Serial Channel-Enable Slave with Fault Readback and Pass-Through

This block is the serial front end of an eight-channel output driver controller. It is a slave on a four-wire serial link with an active-high select. A host sends an 8-bit channel-enable command, and in the same transfer the block returns the latched fault byte. After the fault byte has gone out, the data output repeats the input stream delayed by eight serial clocks. This lets several devices share one select line in a chain, where each device passes on the bytes meant for the devices further along.

All serial inputs are resampled by a fast system clock. Select runs through a glitch filter. When select is released, the block checks the transfer. If it was well formed, the last complete byte received becomes the channel enables and the sticky fault register is cleared. If it was not, neither changes. Between transfers, the fault inputs are ORed into the fault register. A minimum low time on select is enforced before a new transfer may begin.

Top module: `drv_serial_top`

## Requirements
- R1: After reset, `chanEn` is all zeros and `dataOutEn` is 0.
- R2: `dataOutEn` is 1 for the whole of an accepted select period and 0 outside it.
- R3: The first 8 bits on `dataOut` in a transfer are the fault register as it stood when select was accepted, sent MSB first. Each bit is valid before the corresponding SCLK rising edge.
- R4: From the ninth bit onward, `dataOut` repeats the `dataIn` bit sampled eight SCLK rising edges earlier.
- R5: `dataIn` is sampled on SCLK rising edges. `dataOut` changes only after SCLK falling edges and holds steady while SCLK is high.
- R6: Bytes arrive MSB first. The first bit of the last complete byte lands in `chanEn[7]` and the last bit lands in `chanEn[0]`. A 1 turns a channel on.
- R7: A valid transfer has a nonzero multiple of 8 rising edges, SCLK low when select falls, and SCLK low when select rises. When select falls after a valid transfer, `chanEn` takes the last byte received and the fault register clears.
- R8: A transfer whose bit count is not a nonzero multiple of 8 changes neither `chanEn` nor the fault register. This includes a transfer with zero bits.
- R9: A transfer that ends with SCLK high changes neither `chanEn` nor the fault register.
- R10: A transfer that starts with SCLK high changes neither `chanEn` nor the fault register.
- R11: A select pulse shorter than `GLITCH_CYCLES` system clocks is ignored. `dataOutEn` stays 0, and the enables and faults are untouched.
- R12: A select that rises fewer than `MIN_IDLE_CYCLES` system clocks after the previous release starts no transfer. `dataOutEn` stays 0, and clocks shifted during it have no effect.
- R13: Between transfers, each fault input that is 1 for any clock sets its fault bit, and that bit stays set until a valid transfer clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCLK rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the host |
| csIn | input | 1 | Active-high select from the host |
| dataIn | input | 1 | Serial data from the host |
| faultIn | input | 8 | Fault flags from the channel monitors |
| dataOut | output | 1 | Serial data to the host |
| dataOutEn | output | 1 | Drive enable for the serial data output |
| chanEn | output | 8 | Channel enable commands; bit 7 corresponds to channel 8 |

## Verification
The rejection paths are the hardest to reach from the ports. A rejected transfer changes nothing the host can see at release, so each invalid case (odd bit count, SCLK high at either end, glitch, early reselect) is followed by a valid probe transfer. The fault byte that probe reads back shows whether the rejected transfer cleared the register, and the enables are compared against the value expected from the last valid command. The early-reselect case drops select for just long enough to pass the glitch filter but not the idle window, then clocks a full byte.

// File: rtl/drv_serial_pkg.sv
package drv_serial_pkg;
  // Strobes issued by the control FSM to the datapath, one clock wide.
  typedef struct packed {
    logic sessStart;  // select accepted: load fault snapshot, clear counters
    logic commit;     // valid release: apply command, clear faults
    logic sclkRise;   // synchronized SCLK rising edge inside a session
    logic sclkFall;   // synchronized SCLK falling edge inside a session
  } ctlStrobes_t;
endpackage

// File: rtl/drv_serial_sync.sv
module drv_serial_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], asyncIn};
  end

  assign syncOut = pipe[STAGES-1];
endmodule

// File: rtl/drv_serial_ctl.sv
module drv_serial_ctl
  import drv_serial_pkg::*;
#(
  parameter int GLITCH_CYCLES   = 4,
  parameter int MIN_IDLE_CYCLES = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkS,
  input  logic        csS,
  input  logic        bitCntZero,
  input  logic        byteSeen,
  output ctlStrobes_t strobes,
  output logic        sessionActive
);
  localparam int GW = $clog2(GLITCH_CYCLES + 1);
  localparam int IW = $clog2(MIN_IDLE_CYCLES + 1);
  localparam logic [GW-1:0] GLITCH_LAST = GW'(GLITCH_CYCLES - 1);
  localparam logic [IW-1:0] IDLE_DONE   = IW'(MIN_IDLE_CYCLES);

  logic          csFilt, csFiltPrev, sclkPrev, startLow;
  logic [GW-1:0] glitchCnt;
  logic [IW-1:0] idleCnt;
  logic          csFiltRise, csFiltFall, sessEnd;

  // Select glitch filter: the filtered value follows only after the
  // synchronized input has differed for GLITCH_CYCLES consecutive clocks.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csFilt    <= 1'b0;
      glitchCnt <= '0;
    end else if (csS != csFilt) begin
      if (glitchCnt == GLITCH_LAST) begin
        csFilt    <= csS;
        glitchCnt <= '0;
      end else begin
        glitchCnt <= glitchCnt + 1'b1;
      end
    end else begin
      glitchCnt <= '0;
    end
  end

  // Low-time counter; saturates once the reload window has passed.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  idleCnt <= IDLE_DONE;
    else if (csFilt)            idleCnt <= '0;
    else if (idleCnt != IDLE_DONE) idleCnt <= idleCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csFiltPrev <= 1'b0;
      sclkPrev   <= 1'b0;
    end else begin
      csFiltPrev <= csFilt;
      sclkPrev   <= sclkS;
    end
  end

  assign csFiltRise = csFilt & ~csFiltPrev;
  assign csFiltFall = ~csFilt & csFiltPrev;
  assign sessEnd    = csFiltFall & sessionActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sessionActive <= 1'b0;
      startLow      <= 1'b0;
    end else if (strobes.sessStart) begin
      sessionActive <= 1'b1;
      startLow      <= ~sclkS;
    end else if (csFiltFall) begin
      sessionActive <= 1'b0;
    end
  end

  always_comb begin
    strobes.sessStart = csFiltRise & (idleCnt == IDLE_DONE);
    strobes.sclkRise  = sessionActive & sclkS & ~sclkPrev;
    strobes.sclkFall  = sessionActive & ~sclkS & sclkPrev;
    strobes.commit    = sessEnd & bitCntZero & byteSeen & ~sclkS & startLow;
  end
endmodule

// File: rtl/drv_serial_dp.sv
module drv_serial_dp
  import drv_serial_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             sessionActive,
  input  logic             diS,
  input  logic [WIDTH-1:0] faultIn,
  output logic             dataOut,
  output logic [WIDTH-1:0] chanEn,
  output logic             bitCntZero,
  output logic             byteSeen
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] CNT_LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] faultReg, txShift, rxShift;
  logic [CW-1:0]    bitCnt;
  logic             inBit;

  // Sticky fault capture, frozen during a session, cleared on commit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               faultReg <= '0;
    else if (strobes.commit) faultReg <= '0;
    else if (!sessionActive) faultReg <= faultReg | faultIn;
  end

  // Receive side: sample on SCLK rise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBit    <= 1'b0;
      rxShift  <= '0;
      bitCnt   <= '0;
      byteSeen <= 1'b0;
    end else if (strobes.sessStart) begin
      bitCnt   <= '0;
      byteSeen <= 1'b0;
    end else if (strobes.sclkRise) begin
      inBit   <= diS;
      rxShift <= {rxShift[WIDTH-2:0], diS};
      bitCnt  <= bitCnt + 1'b1;
      if (bitCnt == CNT_LAST) byteSeen <= 1'b1;
    end
  end

  // Transmit side: fault snapshot first, then the delayed input stream.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 txShift <= '0;
    else if (strobes.sessStart) txShift <= faultReg;
    else if (strobes.sclkFall)  txShift <= {txShift[WIDTH-2:0], inBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               chanEn <= '0;
    else if (strobes.commit) chanEn <= rxShift;
  end

  assign dataOut    = txShift[WIDTH-1];
  assign bitCntZero = (bitCnt == '0);
endmodule

// File: rtl/drv_serial_top.sv
module drv_serial_top
  import drv_serial_pkg::*;
#(
  parameter int WIDTH           = 8,
  parameter int SYNC_STAGES     = 2,
  parameter int GLITCH_CYCLES   = 4,
  parameter int MIN_IDLE_CYCLES = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkIn,
  input  logic             csIn,
  input  logic             dataIn,
  input  logic [WIDTH-1:0] faultIn,
  output logic             dataOut,
  output logic             dataOutEn,
  output logic [WIDTH-1:0] chanEn
);
  logic [2:0]  syncVec;
  ctlStrobes_t ctlStb;
  logic        sessionActive, bitCntZero, byteSeen;

  drv_serial_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN),
    .asyncIn({sclkIn, csIn, dataIn}),
    .syncOut(syncVec)
  );

  drv_serial_ctl #(.GLITCH_CYCLES(GLITCH_CYCLES), .MIN_IDLE_CYCLES(MIN_IDLE_CYCLES)) ctl_i (
    .clk(clk), .rstN(rstN),
    .sclkS(syncVec[2]), .csS(syncVec[1]),
    .bitCntZero(bitCntZero), .byteSeen(byteSeen),
    .strobes(ctlStb), .sessionActive(sessionActive)
  );

  drv_serial_dp #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN),
    .strobes(ctlStb), .sessionActive(sessionActive),
    .diS(syncVec[0]), .faultIn(faultIn),
    .dataOut(dataOut), .chanEn(chanEn),
    .bitCntZero(bitCntZero), .byteSeen(byteSeen)
  );

  assign dataOutEn = sessionActive;
endmodule

// File: rtl/drv_serial_chk.sv
module drv_serial_chk #(
  parameter int WIDTH           = 8,
  parameter int MIN_IDLE_CYCLES = 50
) (
  input logic             clk,
  input logic             rstN,
  input logic             dataOut,
  input logic             dataOutEn,
  input logic [WIDTH-1:0] chanEn,
  input logic             sclkFall
);
  localparam int LW = $clog2(MIN_IDLE_CYCLES + 1);
  logic [LW-1:0] lowCnt;

  // Counts released cycles of the data output, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        lowCnt <= LW'(MIN_IDLE_CYCLES);
    else if (dataOutEn)                               lowCnt <= '0;
    else if (lowCnt != LW'(MIN_IDLE_CYCLES))          lowCnt <= lowCnt + 1'b1;
  end

  // R7: enables change only in the cycle a session closes
  a_r7_en_only_at_release: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chanEn) |-> $fell(dataOutEn));

  // R5: inside a session the output moves only after an SCLK fall
  a_r5_do_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (dataOutEn && $past(dataOutEn) && !$stable(dataOut)) |-> $past(sclkFall));

  // R12: a new session needs the idle window behind it
  a_r12_idle_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOutEn) |-> (lowCnt >= LW'(MIN_IDLE_CYCLES - 2)));

  // R2: no shifting while the output is released
  a_r2_quiet_when_released: assert property (@(posedge clk) disable iff (!rstN)
    (!dataOutEn && !$past(dataOutEn)) |-> $stable(dataOut));
endmodule

bind drv_serial_top drv_serial_chk #(.WIDTH(WIDTH), .MIN_IDLE_CYCLES(MIN_IDLE_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .dataOut(dataOut), .dataOutEn(dataOutEn),
  .chanEn(chanEn), .sclkFall(ctlStb.sclkFall)
);

// File: tb/drv_serial_top_tb_top.sv
`timescale 1ns/1ps
module drv_serial_top_tb_top;
  localparam int W = 8;
  localparam int GLITCH = 4;
  localparam int IDLE = 50;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, csIn = 1'b0, dataIn = 1'b0;
  logic [W-1:0] faultIn = '0;
  logic dataOut, dataOutEn;
  logic [W-1:0] chanEn;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expEn = '0;

  always #10 clk = ~clk;

  drv_serial_top #(.WIDTH(W), .GLITCH_CYCLES(GLITCH), .MIN_IDLE_CYCLES(IDLE)) dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csIn(csIn), .dataIn(dataIn),
    .faultIn(faultIn), .dataOut(dataOut), .dataOutEn(dataOutEn), .chanEn(chanEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseFault(input logic [W-1:0] f);
    faultIn = f; waitClk(3); faultIn = '0; waitClk(3);
  endtask

  // One select period. DO sampled before each rise and at the end of each high phase.
  task automatic xfer(input logic [31:0] tx, input int n, input bit hiStart, input bit hiEnd,
                      output logic [31:0] rx, output bit enSeen, output bit holdOk);
    rx = '0; holdOk = 1'b1;
    if (hiStart) begin sclkIn = 1'b1; waitClk(HALF); end
    csIn = 1'b1;
    waitClk(20);
    enSeen = dataOutEn;
    if (hiStart) begin sclkIn = 1'b0; waitClk(HALF); end
    for (int i = 0; i < n; i++) begin
      dataIn = tx[n-1-i];
      waitClk(HALF);
      rx[n-1-i] = dataOut;
      sclkIn = 1'b1;
      waitClk(HALF);
      if (dataOut !== rx[n-1-i]) holdOk = 1'b0;
      if (!(hiEnd && i == n-1)) sclkIn = 1'b0;
    end
    waitClk(HALF);
    csIn = 1'b0;
    waitClk(20);
    sclkIn = 1'b0;
    waitClk(IDLE + 20);
  endtask

  // Valid 8-bit transfer; returns the fault byte read back.
  task automatic probe(input logic [W-1:0] cmd, output logic [W-1:0] faultSeen);
    logic [31:0] rx; bit en, hold;
    xfer({24'h0, cmd}, 8, 0, 0, rx, en, hold);
    faultSeen = rx[7:0];
    expEn = cmd;
  endtask

  task automatic testReset();
    check("R1 dataOutEn", {31'h0, dataOutEn}, 32'h0);
    check("R1 chanEn", {24'h0, chanEn}, 32'h0);
  endtask

  task automatic testBasic();
    logic [31:0] rx; bit en, hold;
    pulseFault(8'hA0); pulseFault(8'h05);
    xfer(32'h3C, 8, 0, 0, rx, en, hold);
    check("R2 driven in session", {31'h0, en}, 32'h1);
    check("R2 released after", {31'h0, dataOutEn}, 32'h0);
    check("R3/R13 fault byte", rx[7:0], 32'hA5);
    check("R5 DO steady while SCLK high", {31'h0, hold}, 32'h1);
    check("R6/R7 command applied", {24'h0, chanEn}, 32'h3C);
    expEn = 8'h3C;
  endtask

  task automatic testChain();
    logic [31:0] rx; bit en, hold;
    xfer(32'h96C3, 16, 0, 0, rx, en, hold);
    check("R7 faults cleared", rx[15:8], 32'h00);
    check("R4 pass-through", rx[7:0], 32'h96);
    check("R6 last byte applied", {24'h0, chanEn}, 32'hC3);
    expEn = 8'hC3;
  endtask

  task automatic testOddCount();
    logic [31:0] rx; bit en, hold; logic [W-1:0] f;
    pulseFault(8'h11);
    xfer(32'hF0F, 12, 0, 0, rx, en, hold);
    check("R8 odd count keeps enables", {24'h0, chanEn}, {24'h0, expEn});
    xfer(32'h0, 0, 0, 0, rx, en, hold);
    check("R8 zero bits keeps enables", {24'h0, chanEn}, {24'h0, expEn});
    probe(8'h5A, f);
    check("R8 faults kept", {24'h0, f}, 32'h11);
    check("R7 probe applied", {24'h0, chanEn}, 32'h5A);
  endtask

  task automatic testSclkHighEnd();
    logic [31:0] rx; bit en, hold; logic [W-1:0] f;
    pulseFault(8'h40);
    xfer(32'h81, 8, 0, 1, rx, en, hold);
    check("R9 enables kept", {24'h0, chanEn}, {24'h0, expEn});
    probe(8'h24, f);
    check("R9 faults kept", {24'h0, f}, 32'h40);
  endtask

  task automatic testSclkHighStart();
    logic [31:0] rx; bit en, hold; logic [W-1:0] f;
    pulseFault(8'h02);
    xfer(32'h7E, 8, 1, 0, rx, en, hold);
    check("R10 enables kept", {24'h0, chanEn}, {24'h0, expEn});
    probe(8'h99, f);
    check("R10 faults kept", {24'h0, f}, 32'h02);
  endtask

  task automatic testGlitch();
    bit seen = 1'b0; logic [W-1:0] f;
    pulseFault(8'h08);
    csIn = 1'b1; waitClk(GLITCH - 1); csIn = 1'b0;
    for (int i = 0; i < 20; i++) begin waitClk(1); if (dataOutEn) seen = 1'b1; end
    check("R11 glitch ignored", {31'h0, seen}, 32'h0);
    check("R11 enables kept", {24'h0, chanEn}, {24'h0, expEn});
    waitClk(IDLE);
    probe(8'h66, f);
    check("R11 faults kept", {24'h0, f}, 32'h08);
  endtask

  task automatic testEarlyReselect();
    bit seen = 1'b0; logic [W-1:0] f; logic [7:0] cmd = 8'hE7;
    pulseFault(8'h10);
    csIn = 1'b1; waitClk(20); csIn = 1'b0; waitClk(20);
    csIn = 1'b1; waitClk(20);
    for (int i = 0; i < 8; i++) begin
      dataIn = cmd[7-i];
      waitClk(HALF); if (dataOutEn) seen = 1'b1;
      sclkIn = 1'b1; waitClk(HALF); if (dataOutEn) seen = 1'b1;
      sclkIn = 1'b0;
    end
    waitClk(HALF); csIn = 1'b0; waitClk(20);
    check("R12 no session", {31'h0, seen}, 32'h0);
    check("R12 enables kept", {24'h0, chanEn}, {24'h0, expEn});
    waitClk(IDLE + 20);
    probe(8'h01, f);
    check("R12 faults kept", {24'h0, f}, 32'h10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitClk(5);
    testReset();
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testBasic();
    testChain();
    testOddCount();
    testSclkHighEnd();
    testSclkHighStart();
    testGlitch();
    testEarlyReselect();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule